// File: doc/BRIEF.md
# Set/Clear GPIO Port

This block is a general-purpose I/O port of up to 32 pins behind a plain synchronous register bus: an address, a write strobe, write data, and combinational read data. For each pin it keeps a direction bit and an output latch bit, and it samples the pad input through a synchronizer clocked by the port clock. The pad output follows the output latch. The pad output enable is the inverse of the direction bit, so a direction bit of 1 makes the pin an input.

Software never rewrites the whole output latch. Pins are driven high through a write-one-to-set address and driven low through a write-one-to-clear address. Each of these writes affects only the bits written as one, so single pins change without a read-modify-write sequence. The input-data address returns the synchronized pad level even on pins configured as outputs. Because of the synchronizer, a read right after a write can still return the old pin level. An interrupt unit next to the port can use the same synchronized inputs.

Top module: `gpio_setclr_port`

## Requirements
- R1: After reset every direction bit is 1, the output latch is 0, pad_out is all zeros and pad_oe is all zeros.
- R2: A write to word address 0 (direction) replaces the whole direction register with bus_wdata. A read of address 0 returns the direction register.
- R3: Each pad_oe bit equals the inverse of its direction bit. Direction 1 means input (driver off) and direction 0 means output (driver on).
- R4: A write to address 2 (set) sets every latch bit whose bus_wdata bit is 1 and leaves every other latch bit unchanged.
- R5: A write to address 3 (clear) clears every latch bit whose bus_wdata bit is 1 and leaves every other latch bit unchanged.
- R6: Writes to address 1 (output-data), address 4 (input-data) and addresses 5 to 7 change neither the direction register nor the output latch.
- R7: A read of address 4 returns the pad_in level from two clocks earlier, through a two-flop synchronizer. This holds whatever the direction bits are.
- R8: A read of address 1, 2 or 3 returns the output latch. A read of an address from 5 to 7 returns zero.
- R9: pad_out equals the output latch on every pin, whatever the direction of that pin.
- R10: bus_rdata is combinational from bus_addr and register state. A write takes effect at the next clock edge, so a read in the same cycle as the write returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | PIN_W | Write data, one bit per pin |
| bus_rdata | output | PIN_W | Read data for bus_addr |
| pad_in | input | PIN_W | Asynchronous pad input levels |
| pad_out | output | PIN_W | Pad output levels |
| pad_oe | output | PIN_W | Pad output enables, 1 means driven |

## Verification
The assertions assume that bus_addr, bus_we and bus_wdata are stable around each rising clock edge. The stimulus keeps to this by driving those signals only at falling edges. The synchronizer assertion also treats pad_in as a value sampled at clock edges, so the bench changes pad_in only at falling edges and holds it for at least two cycles before it checks a level. The bench sweeps every 8-bit set, clear and direction pattern against an arithmetic model of the latch.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
   localparam int unsigned REG_DIR = 0;
   localparam int unsigned REG_OUT = 1;
   localparam int unsigned REG_SET = 2;
   localparam int unsigned REG_CLR = 3;
   localparam int unsigned REG_IN  = 4;
   localparam int unsigned REG_CNT = 5;
endpackage

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync #(
   parameter int unsigned PIN_W  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIN_W-1:0] async_i,
   output logic [PIN_W-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sc_sync: STAGES must be at least 2");
   end

   logic [PIN_W-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q[s] <= '0;
         end else if (s == 0) begin
            chain_q[s] <= async_i;
         end else begin
            chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_sc_regs.sv
module gpio_sc_regs
   import gpio_sc_pkg::*;
#(
   parameter int unsigned PIN_W  = 32,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [PIN_W-1:0]  wdata,
   output logic [PIN_W-1:0]  dir_q,
   output logic [PIN_W-1:0]  lat_q
);
   logic dir_wr, set_wr, clr_wr;

   assign dir_wr = we && (addr == ADDR_W'(REG_DIR));
   assign set_wr = we && (addr == ADDR_W'(REG_SET));
   assign clr_wr = we && (addr == ADDR_W'(REG_CLR));

   for (genvar p = 0; p < PIN_W; p++) begin : g_pin
      logic set_b, clr_b;
      assign set_b = set_wr && wdata[p];
      assign clr_b = clr_wr && wdata[p];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dir_q[p] <= 1'b1;
            lat_q[p] <= 1'b0;
         end else begin
            if (dir_wr) begin
               dir_q[p] <= wdata[p];
            end
            if (clr_b) begin
               lat_q[p] <= 1'b0;
            end else if (set_b) begin
               lat_q[p] <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/gpio_sc_rdmux.sv
module gpio_sc_rdmux
   import gpio_sc_pkg::*;
#(
   parameter int unsigned PIN_W  = 32,
   parameter int unsigned ADDR_W = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [PIN_W-1:0]  dir_q,
   input  logic [PIN_W-1:0]  lat_q,
   input  logic [PIN_W-1:0]  in_q,
   output logic [PIN_W-1:0]  rdata
);
   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(REG_DIR)) begin
         rdata = dir_q;
      end else if ((addr == ADDR_W'(REG_OUT)) || (addr == ADDR_W'(REG_SET)) ||
                   (addr == ADDR_W'(REG_CLR))) begin
         rdata = lat_q;
      end else if (addr == ADDR_W'(REG_IN)) begin
         rdata = in_q;
      end
   end
endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
   import gpio_sc_pkg::*;
#(
   parameter int unsigned PIN_W       = 32,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [PIN_W-1:0]  bus_wdata,
   output logic [PIN_W-1:0]  bus_rdata,
   input  logic [PIN_W-1:0]  pad_in,
   output logic [PIN_W-1:0]  pad_out,
   output logic [PIN_W-1:0]  pad_oe
);
   if (PIN_W < 1 || PIN_W > 32) begin : g_bad_width
      $error("gpio_setclr_port: PIN_W must be 1..32");
   end
   if ((1 << ADDR_W) < REG_CNT) begin : g_bad_addr
      $error("gpio_setclr_port: ADDR_W too small for register map");
   end

   logic [PIN_W-1:0] dir_q, lat_q, in_q;

   gpio_sc_regs #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) regs_i (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (bus_addr),
      .we    (bus_we),
      .wdata (bus_wdata),
      .dir_q (dir_q),
      .lat_q (lat_q)
   );

   gpio_sc_sync #(.PIN_W(PIN_W), .STAGES(SYNC_STAGES)) sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pad_in),
      .sync_o  (in_q)
   );

   gpio_sc_rdmux #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) rdmux_i (
      .addr  (bus_addr),
      .dir_q (dir_q),
      .lat_q (lat_q),
      .in_q  (in_q),
      .rdata (bus_rdata)
   );

   assign pad_out = lat_q;
   assign pad_oe  = ~dir_q;
endmodule

// File: rtl/gpio_setclr_port_chk.sv
module gpio_setclr_port_chk
   import gpio_sc_pkg::*;
#(
   parameter int unsigned PIN_W  = 32,
   parameter int unsigned ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [PIN_W-1:0]  bus_wdata,
   input logic [PIN_W-1:0]  bus_rdata,
   input logic [PIN_W-1:0]  pad_in,
   input logic [PIN_W-1:0]  pad_out,
   input logic [PIN_W-1:0]  pad_oe
);
   logic [1:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) age_q <= '0;
      else if (age_q != 2'd3) age_q <= age_q + 2'd1;
   end

   // R3: read-back direction is the inverse of the driver enables
   a_r3_oe_inverse: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(REG_DIR)) |-> (bus_rdata == ~pad_oe));

   // R4
   a_r4_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(REG_SET)) |=>
      (pad_out == ($past(pad_out) | $past(bus_wdata))));

   // R5
   a_r5_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(REG_CLR)) |=>
      (pad_out == ($past(pad_out) & ~$past(bus_wdata))));

   // R6
   a_r6_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr != ADDR_W'(REG_DIR) && bus_addr != ADDR_W'(REG_SET) &&
       bus_addr != ADDR_W'(REG_CLR)) |=> ($stable(pad_out) && $stable(pad_oe)));

   // R7
   a_r7_sync_two: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q >= 2'd2 && bus_addr == ADDR_W'(REG_IN)) |-> (bus_rdata == $past(pad_in, 2)));

   // R9
   a_r9_out_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(REG_OUT)) |-> (bus_rdata == pad_out));
endmodule

bind gpio_setclr_port gpio_setclr_port_chk #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_in    (pad_in),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe)
);

// File: tb/gpio_setclr_port_tb_top.sv
`timescale 1ns/1ps
module gpio_setclr_port_tb_top;
   localparam int W = 8;
   localparam int A = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [A-1:0] bus_addr = '0;
   logic         bus_we = 1'b0;
   logic [W-1:0] bus_wdata = '0;
   logic [W-1:0] bus_rdata;
   logic [W-1:0] pad_in = '0;
   logic [W-1:0] pad_out, pad_oe;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [W-1:0] m_dir, m_lat, rd;

   always #4 clk = ~clk;

   gpio_setclr_port #(.PIN_W(W), .ADDR_W(A)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe));

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [W-1:0] d);
      @(negedge clk);
      bus_addr = A'(a); bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rdv(input int a, output logic [W-1:0] v);
      bus_addr = A'(a); bus_we = 1'b0;
      #1 v = bus_rdata;
   endtask

   task automatic check_state(input string req);
      rdv(0, rd); chk({req, "/R2 dir"}, rd, m_dir);
      chk({req, "/R3 oe"}, pad_oe, ~m_dir);
      chk({req, "/R9 out"}, pad_out, m_lat);
      for (int a = 1; a < 4; a++) begin
         rdv(a, rd); chk({req, "/R8 latch read"}, rd, m_lat);
      end
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      m_dir = '1; m_lat = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 oe", pad_oe, '0);
      chk("R1 out", pad_out, '0);
      rdv(0, rd); chk("R1 dir", rd, '1);
      rdv(1, rd); chk("R1 latch", rd, '0);
      for (int a = 5; a < 8; a++) begin
         rdv(a, rd); chk("R8 unmapped", rd, '0);
      end

      // R4/R5 exhaustive set and clear sweep
      for (int v = 0; v < 256; v++) begin
         wr(2, W'(v)); m_lat = m_lat | W'(v);
         rdv(2, rd); chk("R4 set", rd, m_lat);
         wr(3, W'(v) ^ 8'h5A); m_lat = m_lat & ~(W'(v) ^ 8'h5A);
         rdv(3, rd); chk("R5 clear", rd, m_lat);
         chk("R9 pad_out", pad_out, m_lat);
      end

      // R2/R3 direction sweep
      for (int v = 0; v < 256; v++) begin
         wr(0, W'(v)); m_dir = W'(v);
         rdv(0, rd); chk("R2 dir", rd, m_dir);
         chk("R3 oe", pad_oe, ~m_dir);
      end

      // R6 writes elsewhere have no effect
      wr(2, 8'hC3); m_lat = m_lat | 8'hC3;
      wr(0, 8'h96); m_dir = 8'h96;
      for (int a = 1; a < 8; a++) begin
         if (a != 2 && a != 3) begin
            wr(a, 8'hFF ^ m_lat);
            check_state("R6 ignored");
            wr(a, 8'h00);
            check_state("R6 ignored");
         end
      end

      // R10 same-cycle read returns old value
      @(negedge clk);
      bus_addr = 3'd2; bus_we = 1'b1; bus_wdata = ~m_lat;
      #1 chk("R10 old latch", bus_rdata, m_lat);
      @(negedge clk);
      bus_we = 1'b0; m_lat = '1;
      rdv(2, rd); chk("R10 new latch", rd, m_lat);

      // R7 two-clock synchronizer, with pins as outputs and inputs
      for (int v = 0; v < 256; v += 17) begin
         logic [W-1:0] oldv;
         wr(0, (v[0]) ? 8'hFF : 8'h00);
         oldv = pad_in;
         pad_in = W'(v) ^ 8'hA5;
         rdv(4, rd); chk("R7 same cycle", rd, oldv);
         @(negedge clk);
         rdv(4, rd); chk("R7 one clock", rd, oldv);
         @(negedge clk);
         rdv(4, rd); chk("R7 two clocks", rd, W'(v) ^ 8'hA5);
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule